// File: doc/BRIEF.md
# Trap Delegation and Cause Unit

This block decides, for each trap, which privilege level runs the handler and which cause code is reported for it. Each cycle it looks at the current privilege level (user, supervisor or machine), an exception request with its kind, and the pending interrupt lines. It then picks at most one trap. The result comes out one clock later as a trap pulse, a target level, an interrupt flag and a cause number. Each cause number also serves as a bit index into one of two delegation registers, one for exceptions and one for interrupts. Environment calls and interrupts get a separate code for each privilege level, so software can hand each of them to the supervisor on its own. An illegal instruction uses one code at every level.

The unit also holds the machine interrupt-enable register. Through a small select/write/read port it offers two supervisor views: one of the pending lines and one of the enables. Each view shows only the interrupt bits that have been delegated. A write through the supervisor enable view can change only those bits. A trap never moves to a less privileged level. While the hart runs at machine level, every trap goes to machine level.

Top module: `trap_deleg_unit`

## Requirements
- R1: An exception of kind 0 (illegal instruction) reports cause 2 at every privilege level. An exception of kind 1 (environment call) reports cause 8 from user level (priv 0), 9 from supervisor level (priv 1) and 11 from machine level (priv 3). The interrupt flag is 0 for all of these.
- R2: Interrupt causes are 1 (supervisor software), 3 (machine software), 5 (supervisor timer), 7 (machine timer), 9 (supervisor external) and 11 (machine external). Each one's pending and enable bit sits at the vector position equal to its cause. The interrupt flag is 1.
- R3: An exception goes to supervisor level (mode 1) when the exception delegation bit indexed by its cause is set and the current level is user or supervisor. Otherwise it goes to machine level (mode 3).
- R4: An interrupt's target level is chosen the same way, using the interrupt delegation bit indexed by its cause.
- R5: From machine level every trap goes to machine level, whatever its delegation bit says. Exception delegation bit 11 always reads 0 and ignores writes.
- R6: The supervisor pending view reads pending AND interrupt-delegation. The supervisor enable view reads enable AND interrupt-delegation. A write through the enable view changes only the enable bits whose delegation bit is set.
- R7: An interrupt can be taken only if it is both pending and enabled. If its target level is above the current level, it is always allowed. If its target level equals the current level, it needs that level's global enable (m_gie_i or s_gie_i).
- R8: When several interrupts are eligible at once, the one taken is the first in this list: machine external, machine software, machine timer, supervisor external, supervisor software, supervisor timer.
- R9: If an interrupt is eligible in the same cycle as an exception request, the interrupt is taken.
- R10: Inputs sampled at a clock edge produce trap_o and its fields right after that edge. trap_o never stays high for two cycles in a row: the cycle after a trap takes nothing.
- R11: CSR select map:
  - 0: exception delegation (every bit writable except bit 11).
  - 1: interrupt delegation (only bits 1, 5 and 9 writable).
  - 2: machine enable (only bits 1, 3, 5, 7, 9 and 11 writable).
  - 3: supervisor enable view.
  - 4: pending lines (read only).
  - 5: supervisor pending view (read only).

  The other selects read 0. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| exc_valid_i | input | 1 | Exception request this cycle |
| exc_kind_i | input | 1 | 0 illegal instruction, 1 environment call |
| irq_pend_i | input | 16 | Pending interrupt lines, indexed by cause |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 3 | CSR select |
| csr_wdata_i | input | 16 | CSR write data |
| csr_rdata_o | output | 16 | CSR read data (combinational) |
| trap_o | output | 1 | One-cycle trap-taken pulse |
| trap_mode_o | output | 2 | Handler privilege level |
| trap_irq_o | output | 1 | 1 when the trap is an interrupt |
| trap_cause_o | output | 4 | Cause code |

## Verification
The assertions assume the privilege input holds only the encodings 0, 1 and 3. They also assume a core that raises at most one exception per cycle, and the no-demotion check compares against the privilege seen in the cycle the trap was decided. The stimulus never drives the reserved privilege value 2. Between trap events it returns to an idle cycle with nothing pending, so every scoreboard item lines up with one decision. The back-to-back pulse rule is tested on purpose by holding an interrupt for three cycles. The CSR views are read while machine-level interrupts are masked, so that no trap fires unexpectedly.

// File: rtl/trap_dlg_pkg.sv
package trap_dlg_pkg;

   localparam logic [1:0] MODE_U = 2'b00;
   localparam logic [1:0] MODE_S = 2'b01;
   localparam logic [1:0] MODE_M = 2'b11;

   localparam int CAUSE_ILLEGAL    = 2;
   localparam int CAUSE_ECALL_BASE = 8;
   localparam int CAUSE_ECALL_M    = 11;

   localparam int IRQ_SSI = 1;
   localparam int IRQ_MSI = 3;
   localparam int IRQ_STI = 5;
   localparam int IRQ_MTI = 7;
   localparam int IRQ_SEI = 9;
   localparam int IRQ_MEI = 11;
   localparam int N_IRQ   = 6;

   localparam logic [2:0] SEL_EXC_DLG = 3'd0;
   localparam logic [2:0] SEL_IRQ_DLG = 3'd1;
   localparam logic [2:0] SEL_M_EN    = 3'd2;
   localparam logic [2:0] SEL_S_EN    = 3'd3;
   localparam logic [2:0] SEL_M_PEND  = 3'd4;
   localparam logic [2:0] SEL_S_PEND  = 3'd5;

   // cause number at a given priority rank, rank 0 wins
   function automatic int prio_cause(input int rank);
      case (rank)
         0: return IRQ_MEI;
         1: return IRQ_MSI;
         2: return IRQ_MTI;
         3: return IRQ_SEI;
         4: return IRQ_SSI;
         default: return IRQ_STI;
      endcase
   endfunction

   // handler level: delegated traps from below machine go to supervisor
   function automatic logic [1:0] target_of(input logic dlg_bit, input logic [1:0] priv);
      return (dlg_bit && priv != MODE_M) ? MODE_S : MODE_M;
   endfunction

endpackage

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
   import trap_dlg_pkg::*;
#(
   parameter int            W           = 16,
   parameter logic [W-1:0]  EXC_WMASK   = '1,
   parameter logic [W-1:0]  IRQ_WMASK   = '1,
   parameter logic [W-1:0]  EN_WMASK    = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [2:0]   sel_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] pend_i,
   output logic [W-1:0] rdata_o,
   output logic [W-1:0] exc_dlg_o,
   output logic [W-1:0] irq_dlg_o,
   output logic [W-1:0] irq_en_o
);

   logic [W-1:0] exc_dlg_q, irq_dlg_q, irq_en_q;

   if (W < 12) begin : g_bad_width
      $error("trap_csr_regs: W must cover cause 11");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         exc_dlg_q <= '0;
         irq_dlg_q <= '0;
         irq_en_q  <= '0;
      end else if (we_i) begin
         case (sel_i)
            SEL_EXC_DLG: exc_dlg_q <= wdata_i & EXC_WMASK;
            SEL_IRQ_DLG: irq_dlg_q <= wdata_i & IRQ_WMASK;
            SEL_M_EN:    irq_en_q  <= wdata_i & EN_WMASK;
            SEL_S_EN:    irq_en_q  <= (irq_en_q & ~irq_dlg_q)
                                    | (wdata_i & irq_dlg_q & EN_WMASK);
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel_i)
         SEL_EXC_DLG: rdata_o = exc_dlg_q;
         SEL_IRQ_DLG: rdata_o = irq_dlg_q;
         SEL_M_EN:    rdata_o = irq_en_q;
         SEL_S_EN:    rdata_o = irq_en_q & irq_dlg_q;
         SEL_M_PEND:  rdata_o = pend_i;
         SEL_S_PEND:  rdata_o = pend_i & irq_dlg_q;
         default:     rdata_o = '0;
      endcase
   end

   assign exc_dlg_o = exc_dlg_q;
   assign irq_dlg_o = irq_dlg_q;
   assign irq_en_o  = irq_en_q;

   AST_SEN_KEEPS_UNDELEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == SEL_S_EN) |=> (((irq_en_q ^ $past(irq_en_q)) & ~$past(irq_dlg_q)) == '0)); // R6

   AST_ECALL_M_DLG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == SEL_EXC_DLG) |=> !exc_dlg_q[CAUSE_ECALL_M]); // R5

endmodule

// File: rtl/trap_irq_arb.sv
module trap_irq_arb
   import trap_dlg_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic [N_IRQ-1:0] pend_i,
   input  logic [N_IRQ-1:0] en_i,
   input  logic [N_IRQ-1:0] dlg_i,
   input  logic [1:0]       priv_i,
   input  logic             m_gie_i,
   input  logic             s_gie_i,
   output logic             hit_o,
   output logic [CW-1:0]    cause_o,
   output logic [1:0]       mode_o
);

   logic [N_IRQ-1:0] elig;
   logic [1:0]       tgt_r   [N_IRQ];
   logic [CW-1:0]    cause_r [N_IRQ];

   for (genvar r = 0; r < N_IRQ; r++) begin : g_rank
      localparam int C = prio_cause(r);
      logic allow;
      assign cause_r[r] = CW'(C);
      assign tgt_r[r]   = target_of(dlg_i[r], priv_i);
      always_comb begin
         if (tgt_r[r] > priv_i)        allow = 1'b1;
         else if (tgt_r[r] == MODE_M)  allow = m_gie_i;
         else                          allow = s_gie_i;
      end
      assign elig[r] = pend_i[r] & en_i[r] & allow;
   end

   always_comb begin
      hit_o   = 1'b0;
      cause_o = '0;
      mode_o  = MODE_M;
      for (int r = N_IRQ - 1; r >= 0; r--) begin
         if (elig[r]) begin
            hit_o   = 1'b1;
            cause_o = cause_r[r];
            mode_o  = tgt_r[r];
         end
      end
   end

endmodule

// File: rtl/trap_exc_route.sv
module trap_exc_route
   import trap_dlg_pkg::*;
#(
   parameter int CW = 4,
   localparam int W = 1 << CW
) (
   input  logic          kind_i,
   input  logic [1:0]    priv_i,
   input  logic [W-1:0]  dlg_i,
   output logic [CW-1:0] cause_o,
   output logic [1:0]    mode_o
);

   always_comb begin
      if (kind_i) cause_o = CW'(CAUSE_ECALL_BASE) + CW'(priv_i);
      else        cause_o = CW'(CAUSE_ILLEGAL);
      mode_o = target_of(dlg_i[cause_o], priv_i);
   end

endmodule

// File: rtl/trap_deleg_unit.sv
module trap_deleg_unit
   import trap_dlg_pkg::*;
#(
   parameter int CAUSE_W = 4,
   localparam int W = 1 << CAUSE_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [1:0]         priv_i,
   input  logic               exc_valid_i,
   input  logic               exc_kind_i,
   input  logic [W-1:0]       irq_pend_i,
   input  logic               m_gie_i,
   input  logic               s_gie_i,
   input  logic               csr_we_i,
   input  logic [2:0]         csr_sel_i,
   input  logic [W-1:0]       csr_wdata_i,
   output logic [W-1:0]       csr_rdata_o,
   output logic               trap_o,
   output logic [1:0]         trap_mode_o,
   output logic               trap_irq_o,
   output logic [CAUSE_W-1:0] trap_cause_o
);

   localparam logic [W-1:0] EXC_WMASK = ~(W'(1) << CAUSE_ECALL_M);
   localparam logic [W-1:0] IRQ_WMASK = (W'(1) << IRQ_SSI) | (W'(1) << IRQ_STI)
                                      | (W'(1) << IRQ_SEI);
   localparam logic [W-1:0] EN_WMASK  = IRQ_WMASK | (W'(1) << IRQ_MSI)
                                      | (W'(1) << IRQ_MTI) | (W'(1) << IRQ_MEI);

   if (CAUSE_W < 4) begin : g_bad_cause_w
      $error("trap_deleg_unit: CAUSE_W must be at least 4");
   end

   logic [W-1:0] exc_dlg, irq_dlg, irq_en;

   trap_csr_regs #(
      .W(W), .EXC_WMASK(EXC_WMASK), .IRQ_WMASK(IRQ_WMASK), .EN_WMASK(EN_WMASK)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(csr_we_i), .sel_i(csr_sel_i),
      .wdata_i(csr_wdata_i), .pend_i(irq_pend_i), .rdata_o(csr_rdata_o),
      .exc_dlg_o(exc_dlg), .irq_dlg_o(irq_dlg), .irq_en_o(irq_en)
   );

   // gather the interrupt bits in priority order
   logic [N_IRQ-1:0] pend_r, en_r, dlg_r;
   for (genvar r = 0; r < N_IRQ; r++) begin : g_gather
      localparam int C = prio_cause(r);
      assign pend_r[r] = irq_pend_i[C];
      assign en_r[r]   = irq_en[C];
      assign dlg_r[r]  = irq_dlg[C];
   end

   logic               irq_hit;
   logic [CAUSE_W-1:0] irq_cause, exc_cause;
   logic [1:0]         irq_mode, exc_mode;

   trap_irq_arb #(.CW(CAUSE_W)) u_arb (
      .pend_i(pend_r), .en_i(en_r), .dlg_i(dlg_r), .priv_i(priv_i),
      .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
      .hit_o(irq_hit), .cause_o(irq_cause), .mode_o(irq_mode)
   );

   trap_exc_route #(.CW(CAUSE_W)) u_exc (
      .kind_i(exc_kind_i), .priv_i(priv_i), .dlg_i(exc_dlg),
      .cause_o(exc_cause), .mode_o(exc_mode)
   );

   logic               trap_q, irq_q;
   logic [1:0]         mode_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               take;

   assign take = !trap_q && (irq_hit || exc_valid_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         trap_q  <= 1'b0;
         irq_q   <= 1'b0;
         mode_q  <= MODE_M;
         cause_q <= '0;
      end else begin
         trap_q <= take;
         if (take) begin
            irq_q   <= irq_hit;
            mode_q  <= irq_hit ? irq_mode  : exc_mode;
            cause_q <= irq_hit ? irq_cause : exc_cause;
         end
      end
   end

   assign trap_o       = trap_q;
   assign trap_mode_o  = mode_q;
   assign trap_irq_o   = irq_q;
   assign trap_cause_o = cause_q;

   AST_TRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_q |=> !trap_q); // R10

   AST_EXC_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trap_q && exc_valid_i) |=> trap_q); // R10

   AST_NO_DEMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trap_q && (irq_hit || exc_valid_i)) |=> (mode_q >= $past(priv_i))); // R5

   AST_IRQ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trap_q && irq_hit && exc_valid_i) |=> (trap_q && irq_q)); // R9

   AST_ECALL_M_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_q && !irq_q && cause_q == CAUSE_W'(CAUSE_ECALL_M)) |-> mode_q == MODE_M); // R5

   AST_IRQ_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_hit |-> (irq_pend_i[irq_cause] && irq_en[irq_cause])); // R7

endmodule

// File: tb/trap_deleg_unit_tb_top.sv
`timescale 1ns/1ps
module trap_deleg_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  priv = 2'b11;
   logic        exc_v = 1'b0;
   logic        exc_k = 1'b0;
   logic [15:0] pend = '0;
   logic        mg = 1'b0, sg = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  sel = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        trap, tirq;
   logic [1:0]  tmode;
   logic [3:0]  tcause;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   trap_deleg_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .exc_valid_i(exc_v),
      .exc_kind_i(exc_k), .irq_pend_i(pend), .m_gie_i(mg), .s_gie_i(sg),
      .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
      .trap_o(trap), .trap_mode_o(tmode), .trap_irq_o(tirq), .trap_cause_o(tcause)
   );

   typedef struct {
      logic       trap;
      logic [1:0] mode;
      logic       irq;
      logic [3:0] cause;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   function automatic void check(input bit ok, input string tag,
                                 input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endfunction

   // monitor: compares registered outputs just after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(trap === e.trap, {e.tag, " trap"}, 32'(trap), 32'(e.trap));
            if (e.trap) begin
               check(tmode === e.mode,   {e.tag, " mode"},  32'(tmode),  32'(e.mode));
               check(tirq === e.irq,     {e.tag, " irq"},   32'(tirq),   32'(e.irq));
               check(tcause === e.cause, {e.tag, " cause"}, 32'(tcause), 32'(e.cause));
            end
         end
      end
   end

   task automatic step(input logic [1:0] pv, input logic ev, input logic ek,
                       input logic [15:0] pd, input logic m_g, input logic s_g,
                       input logic et, input logic [1:0] em, input logic ei,
                       input logic [3:0] ec, input string tag);
      exp_t e;
      @(negedge clk);
      priv = pv; exc_v = ev; exc_k = ek; pend = pd; mg = m_g; sg = s_g;
      e.trap = et; e.mode = em; e.irq = ei; e.cause = ec; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      exc_v = 1'b0; pend = '0;
      @(negedge clk);
   endtask

   task automatic csr_wr(input logic [2:0] s, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic csr_chk(input logic [2:0] s, input logic [15:0] exp, input string tag);
      @(negedge clk);
      sel = s;
      #1;
      check(rdata === exp, tag, 32'(rdata), 32'(exp));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(trap === 1'b0, "R11 reset trap", 32'(trap), 0);
      for (int s = 0; s < 8; s++) csr_chk(3'(s), 16'h0000, "R11 reset read");

      // R1 cause codes, nothing delegated (R3 -> machine)
      step(2'b00, 1, 0, 0, 0, 0, 1, 2'b11, 0, 4'd2,  "R1 illegal U"); idle();
      step(2'b11, 1, 0, 0, 0, 0, 1, 2'b11, 0, 4'd2,  "R1 illegal M"); idle();
      step(2'b00, 1, 1, 0, 0, 0, 1, 2'b11, 0, 4'd8,  "R1 ecall U");   idle();
      step(2'b01, 1, 1, 0, 0, 0, 1, 2'b11, 0, 4'd9,  "R1 ecall S");   idle();
      step(2'b11, 1, 1, 0, 0, 0, 1, 2'b11, 0, 4'd11, "R1 ecall M");   idle();

      // R5 / R11 bit 11 hardwired
      csr_wr(3'd0, 16'hFFFF);
      csr_chk(3'd0, 16'hF7FF, "R5 exc dlg bit11 zero");

      // R3 delegated exceptions
      step(2'b00, 1, 1, 0, 0, 0, 1, 2'b01, 0, 4'd8, "R3 ecall U deleg");   idle();
      step(2'b01, 1, 1, 0, 0, 0, 1, 2'b01, 0, 4'd9, "R3 ecall S deleg");   idle();
      step(2'b01, 1, 0, 0, 0, 0, 1, 2'b01, 0, 4'd2, "R3 illegal S deleg"); idle();
      step(2'b11, 1, 1, 0, 0, 0, 1, 2'b11, 0, 4'd11, "R5 ecall M stays");  idle();
      step(2'b11, 1, 0, 0, 0, 0, 1, 2'b11, 0, 4'd2, "R5 illegal M stays"); idle();
      csr_wr(3'd0, 16'h0100);
      step(2'b01, 1, 1, 0, 0, 0, 1, 2'b11, 0, 4'd9, "R3 selective ecall S"); idle();
      step(2'b00, 1, 1, 0, 0, 0, 1, 2'b01, 0, 4'd8, "R3 selective ecall U"); idle();

      // R11 writable masks
      csr_wr(3'd2, 16'hFFFF);
      csr_chk(3'd2, 16'h0AAA, "R11 enable mask");
      csr_wr(3'd1, 16'hFFFF);
      csr_chk(3'd1, 16'h0222, "R11 irq dlg mask");

      // R6 supervisor views, machine masked so nothing traps
      priv = 2'b11; mg = 0; sg = 0;
      @(negedge clk); pend = 16'h0AAA;
      csr_chk(3'd4, 16'h0AAA, "R11 pending read");
      csr_chk(3'd5, 16'h0222, "R6 s pend view");
      csr_chk(3'd3, 16'h0222, "R6 s en view");
      csr_wr(3'd1, 16'h0020);
      csr_chk(3'd5, 16'h0020, "R6 s pend view narrowed");
      csr_wr(3'd3, 16'h0000);
      csr_chk(3'd2, 16'h0A8A, "R6 s en write clears only delegated");
      csr_chk(3'd3, 16'h0000, "R6 s en view after clear");
      csr_wr(3'd3, 16'hFFFF);
      csr_chk(3'd2, 16'h0AAA, "R6 s en write sets only delegated");
      csr_wr(3'd4, 16'h0000);
      csr_chk(3'd4, 16'h0AAA, "R11 pending ignores write");
      idle();

      // R8 priority, R2 codes, R4 delegation (only STI delegated)
      step(2'b00, 0, 0, 16'h0AAA, 0, 0, 1, 2'b11, 1, 4'd11, "R8 MEI first"); idle();
      step(2'b00, 0, 0, 16'h02AA, 0, 0, 1, 2'b11, 1, 4'd3,  "R8 MSI next");  idle();
      step(2'b00, 0, 0, 16'h02A2, 0, 0, 1, 2'b11, 1, 4'd7,  "R8 MTI next");  idle();
      step(2'b00, 0, 0, 16'h0222, 0, 0, 1, 2'b11, 1, 4'd9,  "R4 SEI undeleg"); idle();
      step(2'b00, 0, 0, 16'h0022, 0, 0, 1, 2'b11, 1, 4'd1,  "R2 SSI code");  idle();
      step(2'b00, 0, 0, 16'h0020, 0, 0, 1, 2'b01, 1, 4'd5,  "R4 STI deleg to S"); idle();

      // R7 eligibility
      step(2'b11, 0, 0, 16'h0080, 0, 0, 0, 2'b11, 0, 4'd0, "R7 M gie off"); idle();
      step(2'b11, 0, 0, 16'h0080, 1, 0, 1, 2'b11, 1, 4'd7, "R7 M gie on");  idle();
      step(2'b01, 0, 0, 16'h0020, 0, 0, 0, 2'b01, 0, 4'd0, "R7 S gie off"); idle();
      step(2'b01, 0, 0, 16'h0020, 0, 1, 1, 2'b01, 1, 4'd5, "R7 S gie on");  idle();
      step(2'b01, 0, 0, 16'h0080, 0, 0, 1, 2'b11, 1, 4'd7, "R7 higher target"); idle();
      step(2'b11, 0, 0, 16'h0020, 0, 1, 0, 2'b11, 0, 4'd0, "R5 deleg irq in M masked"); idle();
      step(2'b11, 0, 0, 16'h0020, 1, 0, 1, 2'b11, 1, 4'd5, "R5 deleg irq in M to M"); idle();

      // R9 interrupt beats exception
      step(2'b00, 1, 0, 16'h0080, 0, 0, 1, 2'b11, 1, 4'd7, "R9 irq over exc"); idle();

      // R10 single-cycle pulse with held interrupt
      step(2'b00, 0, 0, 16'h0080, 0, 0, 1, 2'b11, 1, 4'd7, "R10 first");
      step(2'b00, 0, 0, 16'h0080, 0, 0, 0, 2'b11, 0, 4'd0, "R10 holdoff");
      step(2'b00, 0, 0, 16'h0080, 0, 0, 1, 2'b11, 1, 4'd7, "R10 again");
      idle();

      // R7 disabled enable blocks interrupt, exception still taken
      csr_wr(3'd2, 16'h0000);
      step(2'b00, 0, 0, 16'h0080, 1, 1, 0, 2'b11, 0, 4'd0, "R7 not enabled"); idle();
      step(2'b00, 1, 0, 16'h0080, 1, 1, 1, 2'b11, 0, 4'd2, "R7 exc when irq off"); idle();

      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule